// File: doc/BRIEF.md
# DRAM Refresh Controller

This block decides when a DRAM array is refreshed and steps through the rows doing it. A free-running request timer, derived from the system clock through a prescaler that produces an internal tick, raises a refresh request at a fixed interval. Each refresh cycle drives a row-strobe enable for a programmable number of clocks, then allows one recovery clock. When the cycle ends, a row-address counter advances. A refresh-in-progress flag covers the whole cycle.

Three control styles are selected at the inputs. In automatic mode the block starts a refresh on its own whenever a request is pending. In handshake mode the pending request is shown on `refresh_req_o`, and the cycle starts only when the outside arbiter returns `grant_i`. When `disable_i` is asserted, automatic requests are suppressed and each rising edge of the external strobe `strobe_i` runs one refresh, which gives externally paced bursts. Holding the strobe for one full internal tick while automatic refresh is enabled clears the request timer. An extend input lengthens all-bank refreshes clock by clock. A test mode splits the address counter into two halves that count independently.

Top module: `rfsh_ctrl`

## Requirements
- R1: After reset, `busy_o`, `row_strobe_o` and `refresh_req_o` are low and `row_addr_o` is zero.
- R2: While `disable_i` is high, each rising edge of `strobe_i` seen while idle starts a refresh at the next clock edge, and `refresh_req_o` stays low.
- R3: While `disable_i` is low, one request is added every TICK_DIV*REQ_TICKS clocks, counted from reset or from a timer clear, and `refresh_req_o` is high whenever a request is pending.
- R4: At most MAX_PEND requests are held pending, and each completed refresh retires exactly one.
- R5: With `hs_mode_i` high, a pending request starts a refresh only at a clock edge where `grant_i` is high. With `hs_mode_i` low, it starts at the first edge at which the block is idle, without a grant.
- R6: Holding `strobe_i` high for TICK_DIV consecutive clocks while `disable_i` is low clears the request timer, so the next request arrives exactly TICK_DIV*REQ_TICKS clocks after the clearing edge. A strobe seen while enabled starts no refresh.
- R7: A refresh keeps `row_strobe_o` high for `cfg_len_i`+1 clocks and then holds one recovery clock with `row_strobe_o` low. `busy_o` is high across both phases.
- R8: With `all_bank_i` high, every clock edge at the end of the base length at which `extend_i` is high keeps `row_strobe_o` high one more clock. With `all_bank_i` low, `extend_i` has no effect.
- R9: With `test_mode_i` low, `row_addr_o` increases by one at the edge that ends each refresh and wraps from all ones to zero. It does not change at any other time.
- R10: With `test_mode_i` high, bits [12:0] and bits [23:13] of `row_addr_o` each increase by one, without carry between them, at the end of each refresh.
- R11: Asserting `disable_i` drops every pending request, so `refresh_req_o` stays low after `disable_i` is negated until the timer produces a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disable_i | input | 1 | Suppress automatic refresh; enable external strobe bursts |
| strobe_i | input | 1 | External refresh strobe / timer clear |
| hs_mode_i | input | 1 | Handshake mode: wait for grant before refreshing |
| grant_i | input | 1 | Grant from the arbiter |
| extend_i | input | 1 | Refresh extension request |
| all_bank_i | input | 1 | Refresh type is all-bank (extension permitted) |
| test_mode_i | input | 1 | Split address counter into two halves |
| cfg_len_i | input | LEN_W | Row-strobe length minus one, in clocks |
| busy_o | output | 1 | Refresh in progress |
| refresh_req_o | output | 1 | Pending refresh request |
| row_addr_o | output | ADDR_W | Refresh row address |
| row_strobe_o | output | 1 | Row-strobe enable for the refresh |

## Verification
A start condition seen at edge E raises `row_strobe_o` from E for `cfg_len_i`+1 clocks, plus one clock per extension edge. The recovery clock follows, and `row_addr_o` and the pending count change at the edge that ends recovery. A timer request lands exactly TICK_DIV*REQ_TICKS edges after reset or after the clearing edge. The bench drives inputs and samples outputs on the falling edge, counts elapsed rising edges from each stimulus, and checks at the first sample after the edge where each result is due. It also checks one sample earlier, so an early request is caught as well as a late one.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_RECV = 2'd2
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int TICK_DIV  = 100,
  parameter int REQ_TICKS = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disable_i,
  input  logic strobe_i,
  output logic req_pulse_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TCK_W = (REQ_TICKS > 1) ? $clog2(REQ_TICKS) : 1;

  logic [PRE_W-1:0] pre_q, hold_q;
  logic [TCK_W-1:0] tick_q;
  logic tick, clr;

  assign tick        = (pre_q == PRE_W'(TICK_DIV - 1));
  assign clr         = strobe_i && !disable_i && (hold_q == PRE_W'(TICK_DIV - 1));
  assign req_pulse_o = !disable_i && !clr && tick && (tick_q == TCK_W'(REQ_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
      hold_q <= '0;
    end else begin
      // strobe held a full tick while enabled restarts the interval
      if (!strobe_i || disable_i || clr) hold_q <= '0;
      else                               hold_q <= hold_q + 1'b1;
      if (disable_i || clr) begin
        pre_q  <= '0;
        tick_q <= '0;
      end else if (tick) begin
        pre_q  <= '0;
        tick_q <= (tick_q == TCK_W'(REQ_TICKS - 1)) ? '0 : tick_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
  parameter int MAX_PEND = 4,
  localparam int PND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             add_i,
  input  logic             retire_i,
  output logic [PND_W-1:0] cnt_o
);
  logic full, empty, inc, dec;

  assign full  = (cnt_o == PND_W'(MAX_PEND));
  assign empty = (cnt_o == '0);
  assign inc   = add_i && !full;
  assign dec   = retire_i && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= '0;
    else if (flush_i)    cnt_o <= '0;
    else if (inc && !dec) cnt_o <= cnt_o + 1'b1;
    else if (dec && !inc) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/rfsh_addr.sv
module rfsh_addr #(
  parameter int ADDR_W = 24,
  parameter int LO_W   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              test_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] nxt;

  generate
    if (LO_W > 0 && LO_W < ADDR_W) begin : g_split
      always_comb begin
        if (test_i) nxt = {addr_o[ADDR_W-1:LO_W] + 1'b1, addr_o[LO_W-1:0] + 1'b1};
        else        nxt = addr_o + 1'b1;
      end
    end else begin : g_flat
      always_comb nxt = addr_o + ADDR_W'(!test_i || test_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (step_i) addr_o <= nxt;
  end
endmodule

// File: rtl/rfsh_cycle.sv
module rfsh_cycle
  import rfsh_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             extend_i,
  input  logic             all_bank_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  output logic             idle_o,
  output logic             strobe_o,
  output logic             done_o
);
  rfsh_state_e state_q;
  logic [LEN_W-1:0] len_q;
  logic last, hold;

  assign last     = (len_q == cfg_len_i);
  assign hold     = extend_i && all_bank_i;
  assign idle_o   = (state_q == ST_IDLE);
  assign strobe_o = (state_q == ST_STRB);
  assign done_o   = (state_q == ST_RECV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_STRB;
          len_q   <= '0;
        end
        ST_STRB: begin
          if (!last)      len_q   <= len_q + 1'b1;
          else if (!hold) state_q <= ST_RECV;
        end
        ST_RECV: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl #(
  parameter int TICK_DIV  = 100,
  parameter int REQ_TICKS = 31,
  parameter int MAX_PEND  = 4,
  parameter int ADDR_W    = 24,
  parameter int LO_W      = 13,
  parameter int LEN_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disable_i,
  input  logic              strobe_i,
  input  logic              hs_mode_i,
  input  logic              grant_i,
  input  logic              extend_i,
  input  logic              all_bank_i,
  input  logic              test_mode_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  output logic              busy_o,
  output logic              refresh_req_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              row_strobe_o
);
  localparam int PND_W = $clog2(MAX_PEND + 1);

  logic req_pulse, idle, done, start, strobe_q, strobe_rise;
  logic [PND_W-1:0] pend_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign strobe_rise   = strobe_i && !strobe_q;
  assign refresh_req_o = !disable_i && (pend_cnt != '0);
  assign start = idle && (disable_i ? strobe_rise
                                    : ((pend_cnt != '0) && (!hs_mode_i || grant_i)));
  assign busy_o = !idle;

  rfsh_timer #(.TICK_DIV(TICK_DIV), .REQ_TICKS(REQ_TICKS)) u_timer (
    .clk_i, .rst_ni, .disable_i, .strobe_i, .req_pulse_o(req_pulse)
  );

  rfsh_pend #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i, .rst_ni, .flush_i(disable_i), .add_i(req_pulse), .retire_i(done),
    .cnt_o(pend_cnt)
  );

  rfsh_cycle #(.LEN_W(LEN_W)) u_cycle (
    .clk_i, .rst_ni, .start_i(start), .extend_i, .all_bank_i, .cfg_len_i,
    .idle_o(idle), .strobe_o(row_strobe_o), .done_o(done)
  );

  rfsh_addr #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_addr (
    .clk_i, .rst_ni, .step_i(done), .test_i(test_mode_i), .addr_o(row_addr_o)
  );
endmodule

// File: rtl/rfsh_ctrl_chk.sv
module rfsh_ctrl_chk #(
  parameter int MAX_PEND = 4,
  parameter int ADDR_W   = 24,
  parameter int LO_W     = 13,
  parameter int PND_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disable_i,
  input logic              extend_i,
  input logic              all_bank_i,
  input logic              test_mode_i,
  input logic              busy_o,
  input logic              refresh_req_o,
  input logic [ADDR_W-1:0] row_addr_o,
  input logic              row_strobe_o,
  input logic [PND_W-1:0]  pend_cnt
);
  p_strobe_in_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_strobe_o |-> busy_o);

  p_start_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> row_strobe_o);

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt <= PND_W'(MAX_PEND));

  p_no_req_dis_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |-> !refresh_req_o);

  p_extend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_strobe_o && extend_i && all_bank_i) |=> row_strobe_o);

  p_addr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(test_mode_i)) |-> row_addr_o == $past(row_addr_o) + 1'b1);

  p_addr_split_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(test_mode_i)) |->
      row_addr_o[LO_W-1:0] == $past(row_addr_o[LO_W-1:0]) + 1'b1);

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(row_addr_o));
endmodule

bind rfsh_ctrl rfsh_ctrl_chk #(
  .MAX_PEND(MAX_PEND), .ADDR_W(ADDR_W), .LO_W(LO_W), .PND_W(PND_W)
) u_chk (
  .clk_i, .rst_ni, .disable_i, .extend_i, .all_bank_i, .test_mode_i,
  .busy_o, .refresh_req_o, .row_addr_o, .row_strobe_o, .pend_cnt
);

// File: tb/rfsh_ctrl_tb.sv
module rfsh_ctrl_tb;
  localparam int TD = 4, RT = 4, AW = 24, LW = 13, NW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dis = 1'b0, stb = 1'b0, hs = 1'b1, gnt = 1'b0, ext = 1'b0, allb = 1'b0, tm = 1'b0;
  logic [NW-1:0] len = '0;
  logic busy, req, rstb;
  logic [AW-1:0] addr;
  logic [AW-1:0] model = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rfsh_ctrl #(.TICK_DIV(TD), .REQ_TICKS(RT), .MAX_PEND(4), .ADDR_W(AW), .LO_W(LW),
              .LEN_W(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .disable_i(dis), .strobe_i(stb), .hs_mode_i(hs),
    .grant_i(gnt), .extend_i(ext), .all_bank_i(allb), .test_mode_i(tm), .cfg_len_i(len),
    .busy_o(busy), .refresh_req_o(req), .row_addr_o(addr), .row_strobe_o(rstb)
  );

  // {len, ext cycles, all_bank, test_mode}
  typedef struct packed { logic [2:0] l; logic [2:0] x; logic a; logic t; } vec_t;
  localparam vec_t VECS [6] = '{
    '{3'd2, 3'd0, 1'b1, 1'b0}, '{3'd0, 3'd0, 1'b0, 1'b0}, '{3'd3, 3'd2, 1'b1, 1'b0},
    '{3'd1, 3'd3, 1'b0, 1'b0}, '{3'd4, 3'd1, 1'b1, 1'b1}, '{3'd7, 3'd0, 1'b0, 1'b1}
  };

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] a, logic t);
    if (t) return {a[AW-1:LW] + 1'b1, a[LW-1:0] + 1'b1};
    return a + 1'b1;
  endfunction

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one burst refresh with measured strobe length
  task automatic burst(input int l, input int x, input bit a, input bit t);
    int cnt = 0;
    int expl = l + 1 + (a ? x : 0);
    len = NW'(l); allb = a; tm = t; ext = (x > 0);
    stb = 1'b1;
    do begin
      @(negedge clk);
      stb = 1'b0;
      if (rstb) cnt++;
      if (cnt == l + 1 + x) ext = 1'b0;
    end while (rstb && cnt < 40);
    ext = 1'b0;
    chk(cnt == expl, "R7/R8 strobe length", cnt, expl);
    chk(busy && !rstb, "R7 recovery clock busy", busy, 1);
    chk(!req, "R2 no request while disabled", req, 0);
    model = nxt(model, t);
    @(negedge clk);
    chk(!busy, "R7 idle after recovery", busy, 0);
    chk(addr == model, t ? "R10 split address step" : "R9 address step", addr, model);
  endtask

  task automatic fast(input bit t);
    tm = t; len = '0; allb = 1'b0;
    stb = 1'b1; @(negedge clk); stb = 1'b0; wn(2);
    model = nxt(model, t);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] base;
    wn(3);
    chk(!busy && !rstb && !req && addr == '0, "R1 reset state", addr, 0);
    rst_n = 1'b1;
    wn(15);
    chk(!req, "R3 no request before interval", req, 0);
    wn(1);
    chk(req, "R3 request at interval", req, 1);
    wn(74);
    // R6: hold strobe one tick while enabled
    stb = 1'b1;
    wn(4);
    chk(!busy && addr == '0, "R6 enabled strobe starts no refresh", busy, 0);
    stb = 1'b0; gnt = 1'b1;
    wn(14);
    chk(addr == AW'(4), "R4 saturated pending drains four", addr, 4);
    chk(!req, "R4 all pending retired", req, 0);
    wn(1);
    chk(!req, "R6 cleared timer no early request", req, 0);
    wn(1);
    chk(req, "R6 request one interval after clear", req, 1);
    gnt = 1'b0; hs = 1'b0;
    wn(40);
    chk(addr == AW'(7), "R5 auto mode refreshes without grant", addr, 7);
    hs = 1'b1;
    wn(10);
    chk(req, "R5 handshake holds request without grant", req, 1);
    chk(addr == AW'(7), "R5 no refresh without grant", addr, 7);
    dis = 1'b1;
    wn(1);
    chk(!req, "R11 request dropped on disable", req, 0);
    dis = 1'b0;
    wn(1);
    chk(!req, "R11 pending cleared after disable", req, 0);
    dis = 1'b1;
    model = addr;
    wn(2);
    foreach (VECS[i]) burst(VECS[i].l, VECS[i].x, VECS[i].a, VECS[i].t);
    // long runs cross the low-half boundary in both modes
    base = model;
    for (int i = 0; i < 8200; i++) fast(1'b1);
    wn(1);
    chk(addr == model, "R10 halves wrap independently", addr, model);
    for (int i = 0; i < 8200; i++) fast(1'b0);
    wn(1);
    chk(addr == model, "R9 carry across halves", addr, model);
    chk(addr != base, "R9 counter advanced", addr, model);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule